// File: doc/BRIEF.md
# Six-Pulse Firing Sequencer

This block produces the six gate lines for one six-pulse thyristor bridge. It takes a firing-angle demand and a phase-locked reference angle that climbs once per mains cycle. It limits the demand to the window allowed for the present operating mode. It then fires the six valves in turn, spaced equally around the cycle, each one when the reference angle reaches the limited demand plus that valve's fixed offset.

Each fired valve keeps its gate asserted until the reference angle has moved a third of a cycle past the firing point. A block input removes all gate drive at once. When the block input is released, the sequencer re-aligns to the valve whose firing point lies next ahead of the reference angle.

All angles are unsigned 12-bit values, 4096 counts per full cycle. The reference wraps from 4095 to 0, and the block treats that wrap as continuous motion. The reference angle is assumed to advance by less than 682 counts per clock.

Top module: `firing_sequencer`

## Requirements
- R1: A valve fires at the first clock edge where its target angle t satisfies 0 < (t − p) mod 4096 ≤ (r − p) mod 4096. Here r is the present reference angle, p is the reference angle at the previous edge, and 0 < (r − p) mod 4096 < 2048. The gate output rises right after that edge, so at a rise (r − t) mod 4096 is less than the step size.
- R2: Valves fire strictly in index order 0,1,2,3,4,5,0,… and the pointer advances by one on every firing.
- R3: The target of valve k is (alpha_eff + off[k]) mod 4096, where off = {0, 683, 1365, 2048, 2731, 3413} for k = 0..5.
- R4: A fired gate stays high and falls at the first edge where (r − t) mod 4096 ≥ 1365, with t being the target it fired at.
- R5: With inv_mode_i low (rectifier), alpha_eff = max(alpha_i, 57).
- R6: With inv_mode_i high (inverter), alpha_eff = min(max(alpha_i, 1138), 1877).
- R7: While block_i is high, every gate output is low in the same cycle, with no clock edge needed, and no valve fires.
- R8: While block_i stays high the pointer does not change. The first unblocked edge fires nothing and loads the pointer with the valve whose target is the nearest one strictly ahead of r, where a target equal to r counts as already passed.
- R9: Synchronous active-low reset clears all gates. The first edge after reset behaves like the first edge after a deblock (R8).
- R10: At most one gate output rises at any edge, including when the target lies across the 4095-to-0 wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ramp_i | input | 12 | Phase-locked reference angle, 4096 counts per cycle |
| alpha_i | input | 12 | Firing-angle demand before limiting |
| inv_mode_i | input | 1 | 1 = inverter limits, 0 = rectifier limit |
| block_i | input | 1 | 1 = suppress all gates and hold the sequence |
| gate_o | output | 6 | Gate drive, bit k for valve k |

## Verification
A wrong pointer or a stale previous-angle register shows up at the ports within one firing interval, about a sixth of a cycle. It appears as a gate rising out of index order, or at an angle more than one step past its target. A wrong per-valve start angle shows up as a gate falling early or late, within the 1365-count hold window of that valve. Clamp and resume faults show up on the first rise after a mode change or deblock. The bench compares every gate line on every cycle against its own model of the requirements, so each of these faults is reported in the cycle it becomes visible.

// File: rtl/fs_pkg.sv
// Shared helpers for the firing sequencer.
// Assumes angles are unsigned fixed-point with 2**ANG_W counts per cycle.
package fs_pkg;

    // Rounded equidistant offset of valve k out of n across a cycle of full counts.
    function automatic int valve_offset(int k, int full, int n);
        return (k * full + n / 2) / n;
    endfunction

endpackage

// File: rtl/fs_alpha_clamp.sv
// Limits the firing-angle demand to the window of the selected mode.
// Rectifier: lower bound only. Inverter: lower and upper bound.
// Assumes bounds fit in ANG_W bits and INV_MIN <= INV_MAX.
module fs_alpha_clamp #(
    parameter int ANG_W    = 12,
    parameter int RECT_MIN = 57,
    parameter int INV_MIN  = 1138,
    parameter int INV_MAX  = 1877
) (
    input  logic [ANG_W-1:0] alpha_i,
    input  logic             inv_mode_i,
    output logic [ANG_W-1:0] alpha_o
);
    localparam logic [ANG_W-1:0] RMIN = ANG_W'(RECT_MIN);
    localparam logic [ANG_W-1:0] IMIN = ANG_W'(INV_MIN);
    localparam logic [ANG_W-1:0] IMAX = ANG_W'(INV_MAX);

    // Select the bounded demand for the active mode.
    always_comb begin
        if (inv_mode_i) begin
            if (alpha_i < IMIN)      alpha_o = IMIN;
            else if (alpha_i > IMAX) alpha_o = IMAX;
            else                     alpha_o = alpha_i;
        end else begin
            alpha_o = (alpha_i < RMIN) ? RMIN : alpha_i;
        end
    end
endmodule

// File: rtl/fs_target_gen.sv
// Computes the firing target of the pointed valve and the valve to resume
// at after a deblock. Offsets are equidistant, rounded to whole counts.
// Assumes N_VALVE >= 2 and the pointer input stays below N_VALVE.
module fs_target_gen
    import fs_pkg::*;
#(
    parameter int ANG_W   = 12,
    parameter int N_VALVE = 6,
    parameter int PTR_W   = $clog2(N_VALVE)
) (
    input  logic [ANG_W-1:0] alpha_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [ANG_W-1:0] ramp_i,
    output logic [ANG_W-1:0] target_o,
    output logic [PTR_W-1:0] resume_o
);
    localparam int FULL = 1 << ANG_W;

    logic [ANG_W-1:0] off_tab [N_VALVE];
    logic [ANG_W-1:0] off_sel;
    logic [ANG_W-1:0] rel;

    for (genvar g = 0; g < N_VALVE; g++) begin : g_off
        assign off_tab[g] = ANG_W'(valve_offset(g, FULL, N_VALVE));
    end

    // Pick the offset of the valve the pointer names.
    always_comb begin
        off_sel = '0;
        for (int k = 0; k < N_VALVE; k++) begin
            if (ptr_i == PTR_W'(k)) off_sel = off_tab[k];
        end
    end

    assign target_o = alpha_i + off_sel;
    assign rel      = ramp_i - alpha_i;

    // Count targets already passed in this cycle; the next one is the resume valve.
    always_comb begin
        int passed;
        passed = 1;
        for (int k = 1; k < N_VALVE; k++) begin
            if (off_tab[k] <= rel) passed = passed + 1;
        end
        resume_o = PTR_W'(passed % N_VALVE);
    end
endmodule

// File: rtl/fs_gate_hold.sv
// One valve's gate stretcher: sets on a firing, clears once the reference
// angle has advanced HOLD counts past the firing target, clears on block.
// Assumes a valve is not re-fired while its gate is still high.
module fs_gate_hold #(
    parameter int ANG_W = 12,
    parameter int HOLD  = 1365
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             block_i,
    input  logic             fire_i,
    input  logic [ANG_W-1:0] start_i,
    input  logic [ANG_W-1:0] ramp_i,
    output logic             gate_o
);
    localparam logic [ANG_W-1:0] HOLD_A = ANG_W'(HOLD);

    logic [ANG_W-1:0] start_q;
    logic [ANG_W-1:0] span;
    logic             gate_q;

    assign span = ramp_i - start_q;

    // Gate state and the target angle it was fired at.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q  <= 1'b0;
            start_q <= '0;
        end else if (block_i) begin
            gate_q  <= 1'b0;
        end else if (fire_i) begin
            gate_q  <= 1'b1;
            start_q <= start_i;
        end else if (gate_q && span >= HOLD_A) begin
            gate_q  <= 1'b0;
        end
    end

    assign gate_o = gate_q;

    AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && !block_i && span < HOLD_A) |=> gate_q); // R4
    AST_BLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |=> !gate_q); // R7
endmodule

// File: rtl/firing_sequencer.sv
// Six-pulse firing sequencer: compares the reference angle against the
// limited demand plus the pointed valve's offset using a modular crossing
// test, fires that valve, stretches its gate and advances the pointer.
// Assumes the reference advances by less than one valve spacing per clock.
module firing_sequencer #(
    parameter int ANG_W    = 12,
    parameter int N_VALVE  = 6,
    parameter int RECT_MIN = 57,
    parameter int INV_MIN  = 1138,
    parameter int INV_MAX  = 1877
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ANG_W-1:0]   ramp_i,
    input  logic [ANG_W-1:0]   alpha_i,
    input  logic               inv_mode_i,
    input  logic               block_i,
    output logic [N_VALVE-1:0] gate_o
);
    localparam int               FULL     = 1 << ANG_W;
    localparam int               HOLD     = FULL / 3;
    localparam int               PTR_W    = $clog2(N_VALVE);
    localparam logic [ANG_W-1:0] HALF_A   = ANG_W'(FULL / 2);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(N_VALVE - 1);

    logic [ANG_W-1:0]   alpha_eff;
    logic [ANG_W-1:0]   target;
    logic [PTR_W-1:0]   resume;
    logic [PTR_W-1:0]   ptr_q;
    logic [ANG_W-1:0]   prev_q;
    logic               resync_q;
    logic [ANG_W-1:0]   d_cur;
    logic [ANG_W-1:0]   d_tgt;
    logic               fire;
    logic [N_VALVE-1:0] fire_vec;
    logic [N_VALVE-1:0] gate_q;

    fs_alpha_clamp #(
        .ANG_W(ANG_W), .RECT_MIN(RECT_MIN), .INV_MIN(INV_MIN), .INV_MAX(INV_MAX)
    ) u_clamp (
        .alpha_i(alpha_i), .inv_mode_i(inv_mode_i), .alpha_o(alpha_eff)
    );

    fs_target_gen #(
        .ANG_W(ANG_W), .N_VALVE(N_VALVE), .PTR_W(PTR_W)
    ) u_tgt (
        .alpha_i(alpha_eff), .ptr_i(ptr_q), .ramp_i(ramp_i),
        .target_o(target), .resume_o(resume)
    );

    assign d_cur = ramp_i - prev_q;
    assign d_tgt = target - prev_q;

    // Crossing test: target lies in (previous angle, present angle].
    always_comb begin
        fire = !block_i && !resync_q && (d_cur != '0) && (d_cur < HALF_A)
               && (d_tgt != '0) && (d_tgt <= d_cur);
    end

    // Sequence pointer, previous angle and re-alignment flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            prev_q   <= '0;
            resync_q <= 1'b1;
        end else begin
            prev_q <= ramp_i;
            if (block_i) begin
                resync_q <= 1'b1;
            end else if (resync_q) begin
                ptr_q    <= resume;
                resync_q <= 1'b0;
            end else if (fire) begin
                ptr_q <= (ptr_q == LAST_PTR) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N_VALVE; g++) begin : g_valve
        assign fire_vec[g] = fire && (ptr_q == PTR_W'(g));
        fs_gate_hold #(.ANG_W(ANG_W), .HOLD(HOLD)) u_hold (
            .clk(clk), .rst_n(rst_n), .block_i(block_i), .fire_i(fire_vec[g]),
            .start_i(target), .ramp_i(ramp_i), .gate_o(gate_q[g])
        );
    end

    assign gate_o = gate_q & {N_VALVE{~block_i}};

    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_q & ~$past(gate_q))); // R10
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (ptr_q == (($past(ptr_q) == LAST_PTR) ? '0 : $past(ptr_q) + 1'b1))); // R2
    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (block_i ##1 block_i) |-> $stable(ptr_q)); // R8
    AST_RECT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_mode_i |-> (alpha_eff >= ANG_W'(RECT_MIN))); // R5
    AST_INV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        inv_mode_i |-> (alpha_eff >= ANG_W'(INV_MIN) && alpha_eff <= ANG_W'(INV_MAX))); // R6
    AST_NO_FIRE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        resync_q |=> $stable(gate_q) || (gate_q == '0) || ($countones(gate_q) <= $countones($past(gate_q)))); // R8
endmodule

// File: tb/sim_firing_sequencer.sv
// Directed bench with a per-cycle behavioural model of the requirements.
// Clock period 10 time units (100 MHz taking 1 ns units).
module sim_firing_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ramp = '0;
    logic [11:0] alpha = '0;
    logic        inv = 1'b0;
    logic        blk = 1'b0;
    logic [5:0]  gate_o;

    int checks = 0;
    int errs = 0;

    int     OFF [6] = '{0, 683, 1365, 2048, 2731, 3413};
    int     m_ptr;
    bit     m_resync;
    int     m_prev;
    bit [5:0] m_gate;
    int     m_start [6];

    bit [5:0] obs_last;
    int     rise_ramp [6];
    int     fall_ramp [6];
    int     n_rise;
    int     last_valve;
    int     first_after;

    firing_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .ramp_i(ramp), .alpha_i(alpha),
        .inv_mode_i(inv), .block_i(blk), .gate_o(gate_o)
    );

    always #5 clk = ~clk;

    initial begin
        #2000000;
        errs++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    function automatic int md(int x);
        return x & 4095;
    endfunction

    function automatic int clampa(int a, bit im);
        if (im) return (a < 1138) ? 1138 : ((a > 1877) ? 1877 : a);
        return (a < 57) ? 57 : a;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int k = 0; k < 6; k++) begin
            rise_ramp[k] = -1;
            fall_ramp[k] = -1;
        end
        n_rise = 0;
        last_valve = -1;
        first_after = -1;
    endtask

    // Model update for one edge from the inputs now applied.
    task automatic model_edge();
        int a, r, dc, t, dt, rel, c;
        bit f;
        a = clampa(int'(alpha), inv);
        r = int'(ramp);
        if (blk) begin
            m_gate = '0;
            m_resync = 1'b1;
        end else begin
            f = 1'b0;
            t = md(a + OFF[m_ptr]);
            if (!m_resync) begin
                dc = md(r - m_prev);
                dt = md(t - m_prev);
                f = (dc != 0) && (dc < 2048) && (dt != 0) && (dt <= dc);
            end
            for (int k = 0; k < 6; k++) begin
                if (f && k == m_ptr) begin
                    m_gate[k] = 1'b1;
                    m_start[k] = t;
                end else if (m_gate[k] && md(r - m_start[k]) >= 1365) begin
                    m_gate[k] = 1'b0;
                end
            end
            if (m_resync) begin
                rel = md(r - a);
                c = 1;
                for (int j = 1; j < 6; j++) if (OFF[j] <= rel) c++;
                m_ptr = c % 6;
                m_resync = 1'b0;
            end else if (f) begin
                m_ptr = (m_ptr + 1) % 6;
            end
        end
        m_prev = r;
    endtask

    // One clock: model, edge, compare outputs, log rises and falls.
    task automatic cyc();
        model_edge();
        @(posedge clk);
        #1;
        chk(gate_o == (blk ? 6'b0 : m_gate), "R1/R3/R4 gate pattern", int'(gate_o), int'(m_gate));
        for (int k = 0; k < 6; k++) begin
            if (gate_o[k] && !obs_last[k]) begin
                if (last_valve >= 0)
                    chk(k == (last_valve + 1) % 6, "R2 firing order", k, (last_valve + 1) % 6);
                if (first_after < 0) first_after = k;
                last_valve = k;
                rise_ramp[k] = int'(ramp);
                n_rise++;
            end
            if (!gate_o[k] && obs_last[k] && !blk) fall_ramp[k] = int'(ramp);
        end
        chk($countones(gate_o & ~obs_last) <= 1, "R10 single rise", $countones(gate_o & ~obs_last), 1);
        obs_last = gate_o;
        @(negedge clk);
    endtask

    task automatic run(int n, int step);
        for (int i = 0; i < n; i++) begin
            ramp = 12'(md(int'(ramp) + step));
            cyc();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        blk = 1'b0;
        ramp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ptr = 0;
        m_resync = 1'b1;
        m_prev = 0;
        m_gate = '0;
        for (int k = 0; k < 6; k++) m_start[k] = 0;
        obs_last = '0;
        clear_log();
    endtask

    // R9: reset state and first edge behaviour.
    task automatic t_reset();
        do_reset();
        chk(gate_o == 6'b0, "R9 gates low after reset", int'(gate_o), 0);
        alpha = 12'd400;
        inv = 1'b0;
        run(3, 8);
        chk(gate_o == 6'b0, "R9 no firing on resync edge", int'(gate_o), 0);
    endtask

    // R5, R3, R4: rectifier floor, offsets and hold from a known ramp.
    task automatic t_rect_floor();
        do_reset();
        alpha = 12'd0;
        inv = 1'b0;
        run(520, 8);
        chk(rise_ramp[0] == 64, "R5 valve0 fires at floor 57", rise_ramp[0], 64);
        chk(rise_ramp[1] == 744, "R3 valve1 target 740", rise_ramp[1], 744);
        chk(rise_ramp[3] == 2112, "R3 valve3 target 2105", rise_ramp[3], 2112);
        chk(fall_ramp[0] == 1424, "R4 valve0 hold ends", fall_ramp[0], 1424);
        chk(fall_ramp[2] == 2792, "R4 valve2 hold ends", fall_ramp[2], 2792);
        chk(n_rise >= 6, "R2 six firings per cycle", n_rise, 6);
    endtask

    // R6: inverter window, lower and upper bound.
    task automatic t_inverter();
        do_reset();
        alpha = 12'd0;
        inv = 1'b1;
        run(270, 16);
        chk(rise_ramp[0] == 1152, "R6 inverter lower bound 1138", rise_ramp[0], 1152);
        do_reset();
        alpha = 12'd4000;
        inv = 1'b1;
        run(270, 16);
        chk(rise_ramp[0] == 1888, "R6 inverter upper bound 1877", rise_ramp[0], 1888);
        chk(rise_ramp[5] == md(1877 + 3413 + 15) / 16 * 16,
            "R6 valve5 with upper bound", rise_ramp[5], md(1877 + 3413 + 15) / 16 * 16);
    endtask

    // R1, R10: targets across the wrap with an uneven step.
    task automatic t_wrap();
        do_reset();
        alpha = 12'd4090;
        inv = 1'b0;
        run(640, 13);
        for (int k = 0; k < 6; k++) begin
            chk(rise_ramp[k] >= 0 && md(rise_ramp[k] - md(4090 + OFF[k])) < 13,
                "R1 fires within one step of target", rise_ramp[k], md(4090 + OFF[k]));
        end
        chk(n_rise >= 11, "R10 no valve skipped over wrap", n_rise, 11);
    endtask

    // R7, R8: immediate block, frozen sequence, resume at next target.
    task automatic t_block();
        int exp_v, best, d;
        do_reset();
        alpha = 12'd455;
        inv = 1'b0;
        run(150, 10);
        chk(gate_o != 6'b0, "R7 gates active before block", int'(gate_o), 3);
        blk = 1'b1;
        #1;
        chk(gate_o == 6'b0, "R7 gates drop without an edge", int'(gate_o), 0);
        @(negedge clk);
        blk = 1'b1;
        cyc();
        run(40, 10);
        chk(gate_o == 6'b0, "R7 gates stay low while blocked", int'(gate_o), 0);
        blk = 1'b0;
        best = 5000;
        exp_v = 0;
        for (int k = 0; k < 6; k++) begin
            d = md(455 + OFF[k] - int'(ramp));
            if (d != 0 && d < best) begin
                best = d;
                exp_v = k;
            end
        end
        first_after = -1;
        last_valve = -1;
        cyc();
        chk(gate_o == 6'b0, "R8 no firing on deblock edge", int'(gate_o), 0);
        run(120, 10);
        chk(first_after == exp_v, "R8 resume at next target", first_after, exp_v);
    endtask

    initial begin
        t_reset();
        t_rect_floor();
        t_inverter();
        t_wrap();
        t_block();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule